// File: doc/BRIEF.md
# Paged Pointer Address Generator

This block holds the program counter and three 16-bit general pointers, and computes the effective address for each memory-reference step of a small 8-bit processor. The memory map is split into sixteen 4 KB pages. Every address calculation changes only the low 12 bits of a pointer, so a sum that runs past either end of a page comes back round inside the same page. The upper 4 bits change only when software swaps a whole pointer, or writes its high byte through the accumulator.

Each cycle the instruction sequencer presents an operation code, a pointer select, the signed displacement byte, the extension register and the accumulator. The block returns the effective address and the byte for the accumulator combinationally in the same cycle. When `op_valid` is high, it updates the pointer file on the next rising clock edge. The supported operations are:

- advancing the program counter before a fetch;
- indexed addressing, which is PC-relative when pointer 0 is selected;
- auto-indexed addressing, which pre-decrements for a negative offset and post-increments otherwise;
- a full swap of a pointer with the program counter;
- a swap of either byte of a pointer with the accumulator.

Top module: `ptr_agen`

## Requirements
- R1: While `rst_n` is low, all four pointers read zero. The first program-counter advance after reset then gives effective address 0x0001.
- R2: Operation code 1 (advance) adds one to the low 12 bits of pointer 0 and keeps bits 15:12. 0x5FFF advances to 0x5000. The effective address is the advanced value.
- R3: Operation code 2 (indexed) gives an address built from two parts. Bits 15:12 come from the selected pointer. Bits 11:0 are the low 12 bits of the selected pointer plus the sign-extended offset, modulo 4096. No pointer changes. With select 0 the base is the current program counter.
- R4: A displacement byte of exactly 0x80 replaces the offset with the extension byte, sign-extended to 12 bits. This applies to indexed and auto-indexed operations.
- R5: For operation code 3 (auto-index) with a negative offset, the selected pointer is first moved by the offset. The new value is both the effective address and the stored value.
- R6: For operation code 3 with an offset of zero or more, the effective address is the old pointer value. The pointer then advances by the offset, and the stride may be more than one.
- R7: Auto-index updates wrap within the pointer's page field and never change bits 15:12.
- R8: Operation code 4 swaps all 16 bits of the selected pointer with pointer 0. The effective address is the old selected pointer.
- R9: Operation code 5 swaps `acc_in` with bits 15:8 of the selected pointer. Operation code 6 does the same with bits 7:0. `acc_out` returns the old pointer byte. For every other operation, `acc_out` equals `acc_in`.
- R10: With `op_valid` low, or with operation code 0 or 7, no pointer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Commits the operation's pointer updates at the next edge |
| op | input | 3 | Operation code: 0 none, 1 advance, 2 indexed, 3 auto-index, 4 pointer swap, 5 high-byte swap, 6 low-byte swap |
| ptr_sel | input | 2 | Pointer select, 0 = program counter |
| disp | input | 8 | Signed displacement byte |
| ext_val | input | 8 | Extension register value |
| acc_in | input | 8 | Accumulator value |
| eff_addr | output | 16 | Effective address |
| acc_out | output | 8 | Byte returned to the accumulator |
| pc_out | output | 16 | Pointer 0 (program counter) |
| p1_out | output | 16 | Pointer 1 |
| p2_out | output | 16 | Pointer 2 |
| p3_out | output | 16 | Pointer 3 |

## Verification
The bench drives pointers to the last bytes of a page and then indexes and auto-indexes across the boundary. A design that carries into bits 15:12 would move to the next page, for example 0x3FFE+5 would give 0x4003 instead of 0x3003. It exercises the 0x80 escape with both positive and negative extension values. A design that missed the escape would offset by -128, and one that zero-extended the extension byte would step forward where it should pre-decrement. It checks that the address is taken before the pointer moves for positive strides and after it moves for negative ones, so a design with the two orders swapped is off by the stride. It also checks that the swap with select 0 and any operation with `op_valid` low leave every pointer unchanged.

// File: rtl/ptr_agen_pkg.sv
package ptr_agen_pkg;

    localparam int ADDR_W  = 16;
    localparam int PAGE_W  = 12;
    localparam int BYTE_W  = 8;
    localparam int NUM_PTR = 4;
    localparam int SEL_W   = $clog2(NUM_PTR);
    localparam int OP_W    = 3;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE    = 3'd0,
        OP_ADVANCE = 3'd1,
        OP_INDEX   = 3'd2,
        OP_AUTOIDX = 3'd3,
        OP_SWAP_PC = 3'd4,
        OP_SWAP_HI = 3'd5,
        OP_SWAP_LO = 3'd6,
        OP_SPARE   = 3'd7
    } agen_op_e;

endpackage

// File: rtl/agen_offset_sel.sv
module agen_offset_sel #(
    parameter int DISP_W = 8,
    parameter int PAGE_W = 12
) (
    input  logic [DISP_W-1:0] disp,
    input  logic [DISP_W-1:0] ext_val,
    output logic [PAGE_W-1:0] offset,
    output logic              negative
);
    localparam logic [DISP_W-1:0] ESCAPE = DISP_W'(1) << (DISP_W - 1);

    logic [DISP_W-1:0] chosen;

    always_comb begin
        chosen = (disp == ESCAPE) ? ext_val : disp;
    end

    generate
        if (PAGE_W > DISP_W) begin : g_widen
            assign offset = {{(PAGE_W - DISP_W){chosen[DISP_W-1]}}, chosen};
        end else begin : g_trim
            assign offset = chosen[PAGE_W-1:0];
        end
    endgenerate

    assign negative = chosen[DISP_W-1];
endmodule

// File: rtl/agen_page_add.sv
module agen_page_add #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 12
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [PAGE_W-1:0] offset,
    output logic [ADDR_W-1:0] result
);
    logic [PAGE_W-1:0] low_sum;

    always_comb begin
        low_sum = base[PAGE_W-1:0] + offset;
        result  = {base[ADDR_W-1:PAGE_W], low_sum};
    end
endmodule

// File: rtl/agen_ptr_file.sv
module agen_ptr_file #(
    parameter int ADDR_W  = 16,
    parameter int NUM_PTR = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PTR-1:0]             wr_en,
    input  logic [NUM_PTR-1:0][ADDR_W-1:0] wr_data,
    output logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_q
);
    genvar gi;
    generate
        for (gi = 0; gi < NUM_PTR; gi++) begin : g_ptr
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ptr_q[gi] <= '0;
                end else if (wr_en[gi]) begin
                    ptr_q[gi] <= wr_data[gi];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/ptr_agen.sv
module ptr_agen
    import ptr_agen_pkg::*;
#(
    parameter int ADDR_W = ptr_agen_pkg::ADDR_W,
    parameter int PAGE_W = ptr_agen_pkg::PAGE_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              op_valid,
    input  logic [ptr_agen_pkg::OP_W-1:0]     op,
    input  logic [ptr_agen_pkg::SEL_W-1:0]    ptr_sel,
    input  logic [ptr_agen_pkg::BYTE_W-1:0]   disp,
    input  logic [ptr_agen_pkg::BYTE_W-1:0]   ext_val,
    input  logic [ptr_agen_pkg::BYTE_W-1:0]   acc_in,
    output logic [ADDR_W-1:0]                 eff_addr,
    output logic [ptr_agen_pkg::BYTE_W-1:0]   acc_out,
    output logic [ADDR_W-1:0]                 pc_out,
    output logic [ADDR_W-1:0]                 p1_out,
    output logic [ADDR_W-1:0]                 p2_out,
    output logic [ADDR_W-1:0]                 p3_out
);
    localparam int HI_LSB = ADDR_W - BYTE_W;

    agen_op_e                          op_e;
    logic [NUM_PTR-1:0][ADDR_W-1:0]    ptr_q;
    logic [NUM_PTR-1:0][ADDR_W-1:0]    wr_data;
    logic [NUM_PTR-1:0]                wr_req;
    logic [NUM_PTR-1:0]                wr_en;
    logic [ADDR_W-1:0]                 sel_ptr;
    logic [ADDR_W-1:0]                 pc_now;
    logic [ADDR_W-1:0]                 moved_ptr;
    logic [ADDR_W-1:0]                 next_pc;
    logic [PAGE_W-1:0]                 offset;
    logic                              off_neg;

    assign op_e    = agen_op_e'(op);
    assign sel_ptr = ptr_q[ptr_sel];
    assign pc_now  = ptr_q[0];

    agen_offset_sel #(.DISP_W(BYTE_W), .PAGE_W(PAGE_W)) u_offset (
        .disp     (disp),
        .ext_val  (ext_val),
        .offset   (offset),
        .negative (off_neg)
    );

    agen_page_add #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_index_add (
        .base   (sel_ptr),
        .offset (offset),
        .result (moved_ptr)
    );

    agen_page_add #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_pc_add (
        .base   (pc_now),
        .offset (PAGE_W'(1)),
        .result (next_pc)
    );

    always_comb begin
        wr_req   = '0;
        wr_data  = ptr_q;
        eff_addr = sel_ptr;
        acc_out  = acc_in;
        unique case (op_e)
            OP_IDLE, OP_SPARE: begin
            end
            OP_ADVANCE: begin
                eff_addr   = next_pc;
                wr_req[0]  = 1'b1;
                wr_data[0] = next_pc;
            end
            OP_INDEX: begin
                eff_addr = moved_ptr;
            end
            OP_AUTOIDX: begin
                eff_addr         = off_neg ? moved_ptr : sel_ptr;
                wr_req[ptr_sel]  = 1'b1;
                wr_data[ptr_sel] = moved_ptr;
            end
            OP_SWAP_PC: begin
                wr_req[0]        = 1'b1;
                wr_data[0]       = sel_ptr;
                wr_req[ptr_sel]  = 1'b1;
                wr_data[ptr_sel] = (ptr_sel == '0) ? sel_ptr : pc_now;
            end
            OP_SWAP_HI: begin
                acc_out          = sel_ptr[ADDR_W-1:HI_LSB];
                wr_req[ptr_sel]  = 1'b1;
                wr_data[ptr_sel] = {acc_in, sel_ptr[HI_LSB-1:0]};
            end
            OP_SWAP_LO: begin
                acc_out          = sel_ptr[BYTE_W-1:0];
                wr_req[ptr_sel]  = 1'b1;
                wr_data[ptr_sel] = {sel_ptr[ADDR_W-1:BYTE_W], acc_in};
            end
            default: begin
            end
        endcase
    end

    assign wr_en = op_valid ? wr_req : '0;

    agen_ptr_file #(.ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR)) u_ptrs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ptr_q   (ptr_q)
    );

    assign pc_out = ptr_q[0];
    assign p1_out = ptr_q[1];
    assign p2_out = ptr_q[2];
    assign p3_out = ptr_q[3];
endmodule

// File: rtl/ptr_agen_checks.sv
module ptr_agen_checks #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [2:0]        op,
    input logic [1:0]        ptr_sel,
    input logic [7:0]        disp,
    input logic [7:0]        ext_val,
    input logic [7:0]        acc_in,
    input logic [ADDR_W-1:0] eff_addr,
    input logic [7:0]        acc_out,
    input logic [ADDR_W-1:0] pc_out,
    input logic [ADDR_W-1:0] p1_out,
    input logic [ADDR_W-1:0] p2_out,
    input logic [ADDR_W-1:0] p3_out
);
    logic [ADDR_W-1:0] picked;

    always_comb begin
        case (ptr_sel)
            2'd0:    picked = pc_out;
            2'd1:    picked = p1_out;
            2'd2:    picked = p2_out;
            default: picked = p3_out;
        endcase
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (pc_out == '0 && p1_out == '0 &&
                                           p2_out == '0 && p3_out == '0);
        end
    end

    assert_pc_page_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == 3'd1) |=>
        (pc_out[ADDR_W-1:PAGE_W] == $past(pc_out[ADDR_W-1:PAGE_W]) &&
         pc_out[PAGE_W-1:0] == $past(pc_out[PAGE_W-1:0]) + PAGE_W'(1)));

    assert_index_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd2) |-> (eff_addr[ADDR_W-1:PAGE_W] == picked[ADDR_W-1:PAGE_W]));

    assert_index_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == 3'd2) |=>
        ($stable(pc_out) && $stable(p1_out) && $stable(p2_out) && $stable(p3_out)));

    assert_post_inc_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd3 && disp != 8'h80 && !disp[7]) |-> (eff_addr == picked));

    assert_autoidx_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == 3'd3 && ptr_sel == 2'd2) |=>
        (p2_out[ADDR_W-1:PAGE_W] == $past(p2_out[ADDR_W-1:PAGE_W])));

    assert_swap_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == 3'd4) |=> (pc_out == $past(picked)));

    assert_hi_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd5) |-> (acc_out == picked[ADDR_W-1:ADDR_W-8]));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid) |=>
        ($stable(pc_out) && $stable(p1_out) && $stable(p2_out) && $stable(p3_out)));
endmodule

bind ptr_agen ptr_agen_checks #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (.*);

// File: tb/ptr_agen_test.sv
module ptr_agen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [1:0]  ptr_sel = 2'd0;
    logic [7:0]  disp = 8'd0;
    logic [7:0]  ext_val = 8'd0;
    logic [7:0]  acc_in = 8'd0;
    logic [15:0] eff_addr;
    logic [7:0]  acc_out;
    logic [15:0] pc_out, p1_out, p2_out, p3_out;

    int checks = 0;
    int errors = 0;
    int model [4];
    bit finished = 0;

    always #10 clk = ~clk;

    ptr_agen uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op),
        .ptr_sel(ptr_sel), .disp(disp), .ext_val(ext_val), .acc_in(acc_in),
        .eff_addr(eff_addr), .acc_out(acc_out), .pc_out(pc_out),
        .p1_out(p1_out), .p2_out(p2_out), .p3_out(p3_out)
    );

    task automatic check(string tag, int actual, int expected, string what);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, actual, expected);
        end
    endtask

    function automatic int page_move(int base, int delta);
        return (base & 'hF000) | (((base & 'hFFF) + delta) & 'hFFF);
    endfunction

    function automatic int signed_off(int d, int e);
        int b = (d == 'h80) ? e : d;
        return (b >= 128) ? b - 256 : b;
    endfunction

    task automatic check_regs(string tag);
        check(tag, int'(pc_out), model[0], "pointer0");
        check(tag, int'(p1_out), model[1], "pointer1");
        check(tag, int'(p2_out), model[2], "pointer2");
        check(tag, int'(p3_out), model[3], "pointer3");
    endtask

    task automatic step(string tag, bit v, int o, int s, int d, int e, int a);
        int exp_ea, exp_acc, off, cur;
        int nxt [4];
        @(negedge clk);
        op_valid = v; op = 3'(o); ptr_sel = 2'(s);
        disp = 8'(d); ext_val = 8'(e); acc_in = 8'(a);
        #1;
        nxt = model;
        cur = model[s];
        off = signed_off(d, e);
        exp_ea = cur;
        exp_acc = a;
        case (o)
            1: begin exp_ea = page_move(model[0], 1); nxt[0] = exp_ea; end
            2: exp_ea = page_move(cur, off);
            3: begin
                nxt[s] = page_move(cur, off);
                exp_ea = (off < 0) ? nxt[s] : cur;
            end
            4: begin nxt[s] = model[0]; nxt[0] = cur; end
            5: begin exp_acc = (cur >> 8) & 'hFF; nxt[s] = (a << 8) | (cur & 'hFF); end
            6: begin exp_acc = cur & 'hFF; nxt[s] = (cur & 'hFF00) | a; end
            default: ;
        endcase
        check(tag, int'(eff_addr), exp_ea, "eff_addr");
        check(tag, int'(acc_out), exp_acc, "acc_out");
        @(posedge clk);
        if (v) model = nxt;
        #1;
        check_regs(tag);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model = '{0, 0, 0, 0};
        #2 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check_regs("R1");
        @(negedge clk);
        rst_n = 1'b1;

        step("R1", 1, 1, 0, 0, 0, 0);          // first fetch at 0x0001
        step("R9", 1, 5, 1, 0, 0, 'h3F);       // P1 high byte
        step("R9", 1, 6, 1, 0, 0, 'hFE);       // P1 = 0x3FFE
        step("R9", 1, 6, 2, 0, 0, 'h40);       // P2 low byte
        step("R9", 1, 2, 1, 'h10, 0, 'h77);    // acc passes through
        step("R3", 1, 2, 1, 'h05, 0, 0);       // wraps to 0x3003
        step("R3", 1, 2, 1, 'hF0, 0, 0);
        step("R3", 1, 2, 0, 'h7F, 0, 0);       // PC-relative
        step("R4", 1, 2, 1, 'h80, 'hFC, 0);    // ext -4
        step("R4", 1, 2, 2, 'h80, 'h10, 0);    // ext +16
        step("R6", 1, 3, 1, 'h02, 0, 0);       // 0x3FFE -> 0x3000
        step("R7", 1, 3, 1, 'hFF, 0, 0);       // pre-dec wraps to 0x3FFF
        step("R5", 1, 3, 2, 'hF8, 0, 0);
        step("R5", 1, 3, 2, 'h80, 'hF0, 0);    // ext negative: pre-dec
        step("R6", 1, 3, 2, 'h00, 0, 0);       // zero stride
        step("R6", 1, 3, 2, 'h80, 'h20, 0);    // ext positive stride
        step("R2", 1, 5, 0, 0, 0, 'h5F);
        step("R2", 1, 6, 0, 0, 0, 'hFF);
        step("R2", 1, 1, 0, 0, 0, 0);          // 0x5FFF -> 0x5000
        step("R8", 1, 4, 3, 0, 0, 0);
        step("R8", 1, 4, 0, 0, 0, 0);
        step("R10", 0, 3, 1, 'h04, 0, 0);
        step("R10", 0, 5, 2, 0, 0, 'hAA);
        step("R10", 1, 7, 2, 0, 0, 0);
        step("R10", 1, 0, 1, 0, 0, 0);

        for (int i = 0; i < 400; i++) begin
            int o = $urandom_range(0, 7);
            int dv = ($urandom_range(0, 7) == 0) ? 'h80 : $urandom_range(0, 255);
            step("R3", $urandom_range(0, 3) != 0, o, $urandom_range(0, 3),
                 dv, $urandom_range(0, 255), $urandom_range(0, 255));
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule